// File: doc/BRIEF.md
# Backplane Bus Transfer Master

This block lets a local processor run data-transfer cycles on an asynchronous, interlocked parallel backplane that uses 16-bit addresses and 16-bit data. The processor supplies a request pulse with an address, an address-modifier code, a read/write flag, write data and, for block transfers, a word count. The block then returns read data, a per-word beat pulse, a completion pulse, or a timeout interrupt.

On the bus side the block does not arbitrate by itself. It raises a want-bus line to an on-board requester and waits for the granted-bus answer. It then drives the address, the modifier code and the write line. It pulls the address strobe low and then the data strobe, and waits for the slave acknowledge. Both the grant and the acknowledge pass through synchronizers. A cycle counter aborts a data strobe that gets no acknowledge within the timeout window. The block serves requests only when the mode strap selects master operation. After a power-fail interrupt it accepts only requests marked as power-fail handling.

Top module: `bpb_master`

## Requirements
- R1: While `mode_strap` is 1 (slave operation), a request pulse is ignored: `want_bus` stays 0 and no strobe is driven.
- R2: An accepted request raises `want_bus` on the next clock edge. Neither strobe goes low until `bus_granted` has been seen high.
- R3: `bus_wr_n` is driven 0 for a write (`req_rnw`=0) and 1 for a read (`req_rnw`=1) during the cycle. On a write, `bus_dout` carries the word supplied on `req_wdata` for that beat.
- R4: The address and modifier code are valid before the address strobe falls. `bus_astrb_n` is low for at least one clock before `bus_dstrb_n` falls. The address is stable while the data strobe is low.
- R5: On a read, `rd_data` holds the word present on `bus_din` when the acknowledge was accepted; it is valid while `beat` is 1. `done` pulses for one clock when a transfer ends normally.
- R6: After an acknowledge the data strobe is released. The address strobe is released only after the acknowledge has returned high. `want_bus` falls one clock after the address strobe is released.
- R7: If no acknowledge arrives, the data strobe stays low for exactly `TMO_CYCLES` clocks. Then both strobes and `want_bus` are released together, `timeout_irq` pulses for one clock, and `done` does not pulse.
- R8: With `req_blk`=1, `req_count` words are moved under one address-strobe period (a count of 0 moves one word). The address steps by 2 per word and wraps modulo 2^16. With `req_blk`=0, exactly one word moves whatever the count.
- R9: The data strobe falls again only when the synchronized acknowledge is high (inactive), so each word is fully interlocked.
- R10: Once `pwr_fail_irq` has pulsed, requests with `pf_xfer`=0 are ignored until reset, and requests with `pf_xfer`=1 are still served.
- R11: After reset `want_bus`, `done`, `beat` and `timeout_irq` are 0, and `bus_astrb_n`, `bus_dstrb_n` and `bus_wr_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 1 | 0 = master operation, 1 = slave (requests ignored) |
| pwr_fail_irq | input | 1 | Power-fail interrupt taken (pulse) |
| pf_xfer | input | 1 | Request belongs to power-fail handling |
| req | input | 1 | One-clock transfer request |
| req_addr | input | 16 | Start address |
| req_am | input | 6 | Address-modifier code |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_blk | input | 1 | Block transfer |
| req_count | input | 8 | Words in a block transfer |
| req_wdata | input | 16 | Write word for the current beat |
| rd_data | output | 16 | Last word read |
| beat | output | 1 | One-clock pulse per acknowledged word |
| done | output | 1 | One-clock pulse on normal completion |
| timeout_irq | output | 1 | One-clock pulse on acknowledge timeout |
| want_bus | output | 1 | Bus wanted, to the on-board requester |
| bus_granted | input | 1 | Bus granted, from the requester |
| bus_addr | output | 16 | Bus address |
| bus_am | output | 6 | Bus address-modifier code |
| bus_wr_n | output | 1 | Write line, low = write |
| bus_astrb_n | output | 1 | Address strobe, active low |
| bus_dstrb_n | output | 1 | Data strobe, active low |
| bus_ack_n | input | 1 | Slave acknowledge, active low |
| bus_din | input | 16 | Read data from the bus |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Drive enable for `bus_dout` |

## Verification
The assertions check on every cycle the local ordering rules:
- the address strobe precedes the data strobe;
- no strobe is driven without a synchronized grant;
- the acknowledge is inactive before a data strobe falls;
- the address holds still under the data strobe;
- both strobes are released when the want-bus line falls;
- the timeout counter stays bounded;
- the strap and power-fail gating apply at acceptance.

The exact timeout length, the per-word address stepping with wrap, the read data and write data carried per beat, the count rules of block mode and the recovery after a timeout are end-to-end properties. They show only in the bench's swept transfers against a modelled slave and requester with varied response delays.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WANT,
      ST_ADDR,
      ST_ASTRB,
      ST_DATA,
      ST_DSREL,
      ST_STEP,
      ST_DONE
   } bpb_state_e;

   function automatic logic strb_hold(input bpb_state_e s);
      return (s == ST_ASTRB) || (s == ST_DATA) || (s == ST_DSREL) || (s == ST_STEP);
   endfunction

   function automatic logic bus_owned(input bpb_state_e s);
      return (s == ST_ADDR) || strb_hold(s);
   endfunction
endpackage

// File: rtl/bpb_sync.sv
module bpb_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      assert_stages_range_R2 : assert (STAGES >= 0 && STAGES <= 4)
         else $error("bpb_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL}};
            else        sh <= (sh << 1) | STAGES'(d);
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bpb_tmo.sv
module bpb_tmo #(
   parameter int TMO_CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CNT_W = $clog2(TMO_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

   initial begin
      assert_tmo_min_R7 : assert (TMO_CYCLES >= 2)
         else $error("bpb_tmo: TMO_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt + CNT_W'(1);
      else          cnt <= '0;
   end

   assign expire = run && (cnt == LAST);

   assert_tmo_bound_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= LAST));
   assert_tmo_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/bpb_seq.sv
module bpb_seq
   import bpb_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int AM_W     = 6,
   parameter int COUNT_W  = 8,
   parameter bit BLOCK_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  in_addr,
   input  logic [AM_W-1:0]    in_am,
   input  logic               in_rnw,
   input  logic               in_blk,
   input  logic [COUNT_W-1:0] in_count,
   input  logic [DATA_W-1:0]  in_wdata,
   input  logic               grant_s,
   input  logic               ack_s,
   input  logic               expire,
   input  logic [DATA_W-1:0]  din,
   output logic               want,
   output logic               astrb_n,
   output logic               dstrb_n,
   output logic               wr_n,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [AM_W-1:0]    am_o,
   output logic [DATA_W-1:0]  dout,
   output logic               doe,
   output logic [DATA_W-1:0]  rdata,
   output logic               beat,
   output logic               done,
   output logic               irq,
   output logic               tmo_run
);
   localparam int STEP_BYTES = DATA_W / 8;
   localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STEP_BYTES);

   initial begin
      assert_width_cfg_R8 : assert ((DATA_W % 8) == 0 && ADDR_W >= 4 && AM_W >= 1 && COUNT_W >= 1)
         else $error("bpb_seq: bad width configuration");
   end

   bpb_state_e          state;
   logic [ADDR_W-1:0]   addr_q;
   logic [AM_W-1:0]     am_q;
   logic                rnw_q;
   logic [COUNT_W-1:0]  remain_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [DATA_W-1:0]   rdata_q;
   logic                beat_q;
   logic                irq_q;
   logic                blk_eff;
   logic [COUNT_W-1:0]  first_remain;

   generate
      if (BLOCK_EN) begin : g_blk_on
         assign blk_eff = in_blk;
      end else begin : g_blk_off
         assign blk_eff = 1'b0;
      end
   endgenerate

   assign first_remain = (blk_eff && (in_count != '0)) ? (in_count - COUNT_W'(1)) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         addr_q   <= '0;
         am_q     <= '0;
         rnw_q    <= 1'b1;
         remain_q <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         beat_q   <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         beat_q <= 1'b0;
         irq_q  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  addr_q   <= in_addr;
                  am_q     <= in_am;
                  rnw_q    <= in_rnw;
                  remain_q <= first_remain;
                  state    <= ST_WANT;
               end
            end
            ST_WANT: begin
               if (grant_s) state <= ST_ADDR;
            end
            ST_ADDR: begin
               wdata_q <= in_wdata;
               state   <= ST_ASTRB;
            end
            ST_ASTRB: begin
               state <= ST_DATA;
            end
            ST_DATA: begin
               if (ack_s) begin
                  if (rnw_q) rdata_q <= din;
                  beat_q <= 1'b1;
                  state  <= ST_DSREL;
               end else if (expire) begin
                  irq_q <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_DSREL: begin
               if (!ack_s) begin
                  if (remain_q != '0) begin
                     remain_q <= remain_q - COUNT_W'(1);
                     addr_q   <= addr_q + ADDR_INC;
                     wdata_q  <= in_wdata;
                     state    <= ST_STEP;
                  end else begin
                     state <= ST_DONE;
                  end
               end
            end
            ST_STEP: begin
               state <= ST_DATA;
            end
            ST_DONE: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign want    = (state != ST_IDLE);
   assign astrb_n = !strb_hold(state);
   assign dstrb_n = (state != ST_DATA);
   assign wr_n    = bus_owned(state) ? rnw_q : 1'b1;
   assign addr_o  = bus_owned(state) ? addr_q : '0;
   assign am_o    = bus_owned(state) ? am_q : '0;
   assign dout    = wdata_q;
   assign doe     = bus_owned(state) && !rnw_q;
   assign rdata   = rdata_q;
   assign beat    = beat_q;
   assign done    = (state == ST_DONE);
   assign irq     = irq_q;
   assign tmo_run = (state == ST_DATA);

   assert_grant_before_strobe_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !astrb_n |-> grant_s);
   assert_as_before_ds_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dstrb_n) |-> $past(!astrb_n));
   assert_addr_stable_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!dstrb_n && $past(!dstrb_n)) |-> $stable(addr_o));
   assert_release_order_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(want) |-> (astrb_n && dstrb_n));
   assert_interlock_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dstrb_n) |-> !ack_s);
   assert_irq_after_strobe_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(!dstrb_n) && dstrb_n && !want));
   assert_done_irq_excl_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !(done && irq));
endmodule

// File: rtl/bpb_master.sv
module bpb_master #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int AM_W        = 6,
   parameter int COUNT_W     = 8,
   parameter int TMO_CYCLES  = 400,
   parameter int SYNC_STAGES = 2,
   parameter bit BLOCK_EN    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_strap,
   input  logic               pwr_fail_irq,
   input  logic               pf_xfer,
   input  logic               req,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [AM_W-1:0]    req_am,
   input  logic               req_rnw,
   input  logic               req_blk,
   input  logic [COUNT_W-1:0] req_count,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic [DATA_W-1:0]  rd_data,
   output logic               beat,
   output logic               done,
   output logic               timeout_irq,
   output logic               want_bus,
   input  logic               bus_granted,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [AM_W-1:0]    bus_am,
   output logic               bus_wr_n,
   output logic               bus_astrb_n,
   output logic               bus_dstrb_n,
   input  logic               bus_ack_n,
   input  logic [DATA_W-1:0]  bus_din,
   output logic [DATA_W-1:0]  bus_dout,
   output logic               bus_doe
);
   logic pf_lat;
   logic accept;
   logic grant_s;
   logic ack_n_s;
   logic ack_s;
   logic expire;
   logic tmo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pf_lat <= 1'b0;
      else        pf_lat <= pf_lat | pwr_fail_irq;
   end

   assign accept = req && !mode_strap && (!pf_lat || pf_xfer);

   bpb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_grant_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_granted), .q(grant_s));

   bpb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_ack_n), .q(ack_n_s));

   assign ack_s = !ack_n_s;

   bpb_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
      .clk(clk), .rst_n(rst_n), .run(tmo_run), .expire(expire));

   bpb_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AM_W(AM_W),
      .COUNT_W(COUNT_W), .BLOCK_EN(BLOCK_EN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .in_addr(req_addr), .in_am(req_am), .in_rnw(req_rnw),
      .in_blk(req_blk), .in_count(req_count), .in_wdata(req_wdata),
      .grant_s(grant_s), .ack_s(ack_s), .expire(expire), .din(bus_din),
      .want(want_bus), .astrb_n(bus_astrb_n), .dstrb_n(bus_dstrb_n),
      .wr_n(bus_wr_n), .addr_o(bus_addr), .am_o(bus_am),
      .dout(bus_dout), .doe(bus_doe), .rdata(rd_data), .beat(beat),
      .done(done), .irq(timeout_irq), .tmo_run(tmo_run));

   assert_strap_gate_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(want_bus) |-> $past(!mode_strap));
   assert_pf_gate_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(want_bus) && $past(pf_lat)) |-> $past(pf_xfer));
   assert_idle_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !want_bus |-> (bus_astrb_n && bus_dstrb_n && bus_wr_n && !bus_doe));
endmodule

// File: tb/test_bpb_master.sv
`timescale 1ns/1ps
module test_bpb_master;
   localparam int TMO = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_strap = 1'b0;
   logic        pwr_fail_irq = 1'b0;
   logic        pf_xfer = 1'b0;
   logic        req = 1'b0;
   logic [15:0] req_addr = '0;
   logic [5:0]  req_am = '0;
   logic        req_rnw = 1'b1;
   logic        req_blk = 1'b0;
   logic [7:0]  req_count = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rd_data;
   logic        beat, done, timeout_irq, want_bus;
   logic        bus_granted = 1'b0;
   logic [15:0] bus_addr;
   logic [5:0]  bus_am;
   logic        bus_wr_n, bus_astrb_n, bus_dstrb_n;
   logic        bus_ack_n = 1'b1;
   logic [15:0] bus_din;
   logic [15:0] bus_dout;
   logic        bus_doe;

   always #2.5 clk = ~clk;

   bpb_master #(.TMO_CYCLES(TMO)) i_bpb_master (
      .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .pwr_fail_irq(pwr_fail_irq),
      .pf_xfer(pf_xfer), .req(req), .req_addr(req_addr), .req_am(req_am),
      .req_rnw(req_rnw), .req_blk(req_blk), .req_count(req_count), .req_wdata(req_wdata),
      .rd_data(rd_data), .beat(beat), .done(done), .timeout_irq(timeout_irq),
      .want_bus(want_bus), .bus_granted(bus_granted), .bus_addr(bus_addr), .bus_am(bus_am),
      .bus_wr_n(bus_wr_n), .bus_astrb_n(bus_astrb_n), .bus_dstrb_n(bus_dstrb_n),
      .bus_ack_n(bus_ack_n), .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe));

   function automatic logic [15:0] rd_val(input logic [15:0] a);
      return (a * 16'd3) ^ 16'h5A5A;
   endfunction

   assign bus_din = rd_val(bus_addr);

   int n_tests = 0;
   int n_fail = 0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // bus-side model state and per-transfer observations
   int s_del = 0, g_del = 0, s_cnt = 0, g_cnt = 0;
   bit s_en = 1'b1;
   int sb = 0, nb = 0;
   int ds_falls = 0, as_rises = 0, want_rises = 0, ds_low = 0;
   int ord_err = 0, il_err = 0, gr_err = 0, rel_err = 0;
   int done_cnt = 0, irq_cnt = 0;
   logic [15:0] wbase = '0;
   logic [15:0] log_addr [0:15];
   logic [15:0] log_wdat [0:15];
   logic        log_wrn  [0:15];
   logic [5:0]  log_am   [0:15];
   logic [15:0] rd_log   [0:15];
   logic p_as = 1'b1, p_ds = 1'b1, p_want = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!p_want && want_bus) want_rises++;
         if (p_as && !bus_astrb_n && !bus_granted) gr_err++;
         if (p_ds && !bus_dstrb_n) begin
            ds_falls++;
            if (p_as) ord_err++;
            if (!bus_ack_n) il_err++;
            if (!bus_granted) gr_err++;
         end
         if (!p_as && bus_astrb_n) as_rises++;
         if (!bus_dstrb_n) ds_low++;
         if (p_want && !want_bus && !p_as && !timeout_irq) rel_err++;
         if (done) done_cnt++;
         if (timeout_irq) irq_cnt++;
         if (beat) begin
            if (nb < 16) rd_log[nb] = rd_data;
            nb++;
            req_wdata = wbase + 16'(nb);
         end
         // slave
         if (bus_ack_n && !bus_dstrb_n && s_en) begin
            if (s_cnt >= s_del) begin
               bus_ack_n = 1'b0;
               if (sb < 16) begin
                  log_addr[sb] = bus_addr;
                  log_wdat[sb] = bus_dout;
                  log_wrn[sb]  = bus_wr_n;
                  log_am[sb]   = bus_am;
               end
               sb++;
            end else s_cnt++;
         end else if (!bus_ack_n && bus_dstrb_n) begin
            bus_ack_n = 1'b1;
            s_cnt = 0;
         end
         // requester
         if (!want_bus) begin
            bus_granted = 1'b0;
            g_cnt = 0;
         end else if (!bus_granted) begin
            if (g_cnt >= g_del) bus_granted = 1'b1;
            else g_cnt++;
         end
      end
      p_as = bus_astrb_n;
      p_ds = bus_dstrb_n;
      p_want = want_bus;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic clear_obs();
      sb = 0; nb = 0; ds_falls = 0; as_rises = 0; want_rises = 0; ds_low = 0;
      ord_err = 0; il_err = 0; gr_err = 0; rel_err = 0; done_cnt = 0; irq_cnt = 0;
   endtask

   task automatic launch(input logic [15:0] a, input logic [5:0] am, input bit rnw,
                         input bit blk, input logic [7:0] cnt, input logic [15:0] wb);
      @(negedge clk);
      clear_obs();
      req_addr = a; req_am = am; req_rnw = rnw; req_blk = blk; req_count = cnt;
      wbase = wb; req_wdata = wb;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic run_xfer(input logic [15:0] a, input logic [5:0] am, input bit rnw,
                           input bit blk, input logic [7:0] cnt, input logic [15:0] wb,
                           input int sd, input int gd);
      int words;
      s_del = sd; g_del = gd; s_en = 1'b1;
      launch(a, am, rnw, blk, cnt, wb);
      for (int w = 0; w < 3000 && done_cnt == 0 && irq_cnt == 0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
      words = (blk && cnt != 0) ? int'(cnt) : 1;
      chk("R5 done count", done_cnt, 1);
      chk("R7 no timeout", irq_cnt, 0);
      chk("R8 beats seen locally", nb, words);
      chk("R8 words seen by slave", sb, words);
      chk("R9 data strobe falls", ds_falls, words);
      chk("R8 one address strobe period", as_rises, 1);
      chk("R4 strobe order", ord_err, 0);
      chk("R9 interlock", il_err, 0);
      chk("R2 strobe before grant", gr_err, 0);
      chk("R6 release order", rel_err, 0);
      chk("R6 want dropped", want_bus, 0);
      for (int i = 0; i < words && i < 16; i++) begin
         chk("R8 beat address", log_addr[i], 16'(a + 16'(2 * i)));
         chk("R3 write line", log_wrn[i], rnw);
         chk("R4 modifier code", log_am[i], am);
         if (!rnw) chk("R3 write data", log_wdat[i], 16'(wb + 16'(i)));
         else      chk("R5 read data", rd_log[i], rd_val(16'(a + 16'(2 * i))));
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      chk("R11 want_bus", want_bus, 0);
      chk("R11 astrb", bus_astrb_n, 1);
      chk("R11 dstrb", bus_dstrb_n, 1);
      chk("R11 wr line", bus_wr_n, 1);
      chk("R11 done", done, 0);
      chk("R11 irq", timeout_irq, 0);
      chk("R11 beat", beat, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3 R5 single reads and writes, count ignored without block mode (R8)
      run_xfer(16'h1234, 6'h3D, 1'b0, 1'b0, 8'd5, 16'hBEEF, 1, 3);
      run_xfer(16'h8000, 6'h29, 1'b1, 1'b0, 8'd7, 16'h0000, 0, 0);

      // sweep: direction x block length x slave delay (R8 block, R9 interlock, R2 grant delay)
      for (int rw = 0; rw < 2; rw++)
         for (int n = 0; n < 5; n++)
            for (int d = 0; d < 3; d++)
               run_xfer(16'(16'h0100 * (rw * 15 + n * 3 + d) + 16'h0040),
                        6'(6'h39 ^ (n + d)), rw[0], 1'b1, 8'(n),
                        16'(16'h1000 * n + d), d, n);

      // R8 address wrap
      run_xfer(16'hFFFE, 6'h3E, 1'b1, 1'b1, 8'd3, 16'h0, 2, 1);

      // R7 timeout: no acknowledge
      s_en = 1'b0; g_del = 1;
      launch(16'h0200, 6'h3D, 1'b1, 1'b0, 8'd0, 16'h0);
      for (int w = 0; w < 3000 && irq_cnt == 0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R7 irq pulses", irq_cnt, 1);
      chk("R7 strobe low cycles", ds_low, TMO);
      chk("R7 no done", done_cnt, 0);
      chk("R7 want released", want_bus, 0);
      chk("R7 astrb released", bus_astrb_n, 1);
      s_en = 1'b1;
      run_xfer(16'h0300, 6'h3D, 1'b0, 1'b0, 8'd0, 16'h5555, 0, 0);

      // R1 strap selects slave operation
      mode_strap = 1'b1;
      launch(16'h0400, 6'h3D, 1'b1, 1'b0, 8'd0, 16'h0);
      repeat (30) @(negedge clk);
      chk("R1 no want while strapped", want_rises, 0);
      chk("R1 no strobe while strapped", ds_falls, 0);
      mode_strap = 1'b0;
      run_xfer(16'h0500, 6'h3D, 1'b1, 1'b0, 8'd0, 16'h0, 0, 0);

      // R10 power-fail gating
      @(negedge clk); pwr_fail_irq = 1'b1;
      @(negedge clk); pwr_fail_irq = 1'b0;
      pf_xfer = 1'b0;
      launch(16'h0600, 6'h3D, 1'b1, 1'b0, 8'd0, 16'h0);
      repeat (30) @(negedge clk);
      chk("R10 ordinary request ignored", want_rises, 0);
      chk("R10 no strobe", ds_falls, 0);
      pf_xfer = 1'b1;
      run_xfer(16'h0700, 6'h3D, 1'b0, 1'b1, 8'd2, 16'hA000, 1, 2);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule